// File: doc/BRIEF.md
# Two-Reference Automatic Selection Controller

This block is the mode controller of a clock synchronizer that can follow either of two input references. It keeps one reference active and reports which one that is. When the active reference is flagged as disrupted or out of range, the controller moves into holdover and raises a failure flag. If the fault clears in time, it returns to the same reference. If the fault outlasts a disqualify interval, it moves to the other reference.

Any change of reference passes through a phase-realignment mode on the way back to normal tracking. A holdover-merge select also routes a plain recovery through that mode. The lock indication qualifies over a configurable number of millisecond ticks, and it survives a reference swap only while the phase stays inside the lock window.

Time is counted on a one-cycle millisecond tick. The disqualify interval and the lock-qualify time are parameters, so a simulation can shorten both.

Top module: `refsel_ctrl`

## Requirements
- R1: After reset the mode is Normal (`mode`=0), `sel_ref`=0, and `holdover`, `ref_fail`, `lock` and `ref_chg` are all low.
- R2: In Normal, the cycle after the selected reference shows `ref_dis` or `ref_oor` high (bit 0 is reference 0, bit 1 is reference 1), the mode becomes Holdover (`mode`=1). Flags of the reference that is not selected have no effect.
- R3: `holdover` and `ref_fail` are both high exactly while the mode is Holdover. They are low in Normal and in TIE Correction (`mode`=2).
- R4: In Holdover, if the selected reference becomes clean before `QUAL_MS` ticks have passed and `merge_sel`=0, the next mode is Normal with the same `sel_ref`.
- R5: In Holdover, if the selected reference becomes clean and `merge_sel`=1, the next mode is TIE Correction.
- R6: When the selected reference stays faulty in Holdover for `QUAL_MS` millisecond ticks, `sel_ref` toggles (0 means reference 0 and 1 means reference 1) and `ref_chg` pulses high for exactly one cycle. The mode then moves to TIE Correction, whatever the value of `merge_sel`.
- R7: While both `ref_oor` bits are high, the controller stays in Holdover and never changes reference, however many ticks pass.
- R8: In TIE Correction, the next mode is Normal if the selected reference is clean, and Holdover otherwise.
- R9: `lock` rises on the `LOCK_MS`-th tick while `in_window` is continuously high. It stays high through a reference switch as long as `in_window` stays high.
- R10: When `in_window` is low, `lock` is low in the next cycle, and qualification restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| ref_dis | input | 2 | Per-reference disrupted flags |
| ref_oor | input | 2 | Per-reference out-of-range flags |
| merge_sel | input | 1 | Route recovery from holdover through TIE Correction |
| in_window | input | 1 | Output phase is inside the lock window |
| sel_ref | output | 1 | Active reference index |
| holdover | output | 1 | Holdover indication |
| ref_fail | output | 1 | Active reference failure indication |
| lock | output | 1 | Lock qualified |
| ref_chg | output | 1 | One-cycle reference-change event |
| mode | output | 2 | Mode: 0 Normal, 1 Holdover, 2 TIE Correction |

## Verification
Mode and reference are registered and drive the outputs directly, so a wrong next-state decision shows on `mode`, `holdover` or `sel_ref` one clock after the stimulus. A fault counter that runs off by one surfaces at the disqualify boundary. There the bench holds a fault for exactly one tick short of the interval, then for the full interval, so an early or late switch shows in the cycle of the deciding tick. A lock counter error shows as `lock` rising one tick early or late during qualification.

// File: rtl/refsel_ctrl.sv
module refsel_ctrl #(
  parameter int QUAL_MS = 50,
  parameter int LOCK_MS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic [1:0] ref_dis,
  input  logic [1:0] ref_oor,
  input  logic       merge_sel,
  input  logic       in_window,
  output logic       sel_ref,
  output logic       holdover,
  output logic       ref_fail,
  output logic       lock,
  output logic       ref_chg,
  output logic [1:0] mode
);
  localparam int QW = $clog2(QUAL_MS + 1);
  localparam int LW = $clog2(LOCK_MS + 1);
  localparam logic [1:0] M_NORM = 2'd0, M_HOLD = 2'd1, M_TIE = 2'd2;

  logic [QW-1:0] qual_cnt;
  logic [LW-1:0] lock_cnt;

  wire cur_bad   = ref_dis[sel_ref] | ref_oor[sel_ref];
  wire both_oor  = &ref_oor;
  wire qual_done = ms_tick && (qual_cnt == QW'(QUAL_MS - 1));

  assign holdover = (mode == M_HOLD);
  assign ref_fail = (mode == M_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= M_NORM;
      sel_ref  <= 1'b0;
      ref_chg  <= 1'b0;
      qual_cnt <= '0;
    end else begin
      ref_chg <= 1'b0;
      case (mode)
        M_NORM: begin
          qual_cnt <= '0;
          if (cur_bad) mode <= M_HOLD;
        end
        M_HOLD: begin
          if (both_oor) qual_cnt <= '0;
          else if (!cur_bad) mode <= merge_sel ? M_TIE : M_NORM;
          else if (qual_done) begin
            sel_ref <= ~sel_ref;
            ref_chg <= 1'b1;
            mode    <= M_TIE;
          end else if (ms_tick) qual_cnt <= qual_cnt + 1'b1;
        end
        M_TIE: begin
          qual_cnt <= '0;
          mode     <= cur_bad ? M_HOLD : M_NORM;
        end
        default: mode <= M_NORM;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !in_window) begin
      lock     <= 1'b0;
      lock_cnt <= '0;
    end else if (!lock && ms_tick) begin
      if (lock_cnt == LW'(LOCK_MS - 1)) lock <= 1'b1;
      else lock_cnt <= lock_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/refsel_ctrl_chk.sv
module refsel_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ref_dis,
  input logic [1:0] ref_oor,
  input logic       in_window,
  input logic       sel_ref,
  input logic       holdover,
  input logic       ref_fail,
  input logic       lock,
  input logic       ref_chg,
  input logic [1:0] mode
);
  AST_ENTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && (ref_dis[sel_ref] || ref_oor[sel_ref])) |=> holdover); // R2
  AST_TIE_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (!holdover && !ref_fail)); // R3
  AST_CHG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_chg |=> !ref_chg); // R6
  AST_CHG_SWAPS: assert property (@(posedge clk) disable iff (!rst_n)
    ref_chg |-> (sel_ref != $past(sel_ref))); // R6
  AST_SEL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_chg |-> $stable(sel_ref)); // R6
  AST_BOTH_OOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (holdover && (&ref_oor)) |=> (holdover && !ref_chg)); // R7
  AST_LOCK_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(in_window)); // R9
  AST_WIN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_window |=> !lock); // R10
endmodule

bind refsel_ctrl refsel_ctrl_chk u_chk (.*);

// File: tb/refsel_ctrl_test.sv
module refsel_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0, merge_sel = 1'b0, in_window = 1'b0;
  logic [1:0] ref_dis = 2'b00, ref_oor = 2'b00;
  logic sel_ref, holdover, ref_fail, lock, ref_chg;
  logic [1:0] mode;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct packed { logic [1:0] m; logic s, l, c; } exp_t;
  exp_t exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  refsel_ctrl #(.QUAL_MS(4), .LOCK_MS(3)) uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ref_dis(ref_dis), .ref_oor(ref_oor),
    .merge_sel(merge_sel), .in_window(in_window), .sel_ref(sel_ref), .holdover(holdover),
    .ref_fail(ref_fail), .lock(lock), .ref_chg(ref_chg), .mode(mode));

  task automatic apply(input logic [1:0] d, input logic [1:0] o, input logic mg,
                       input logic w, input logic t, input logic [1:0] em,
                       input logic es, input logic el, input logic ec, input string tag);
    @(negedge clk);
    ref_dis = d; ref_oor = o; merge_sel = mg; in_window = w; ms_tick = t;
    exp_q.push_back('{m: em, s: es, l: el, c: ec});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      string tg;
      logic eh;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      eh = (e.m == 2'd1);
      checks++;
      if (mode !== e.m || sel_ref !== e.s || lock !== e.l || ref_chg !== e.c ||
          holdover !== eh || ref_fail !== eh) begin
        errors++;
        $display("FAIL %s: mode=%0d sel=%0d lock=%0d chg=%0d hold=%0d fail=%0d exp mode=%0d sel=%0d lock=%0d chg=%0d hold=%0d fail=%0d",
                 tg, mode, sel_ref, lock, ref_chg, holdover, ref_fail,
                 e.m, e.s, e.l, e.c, eh, eh);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, exp done=1 got 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (mode !== 2'd0 || sel_ref !== 1'b0 || holdover !== 1'b0 || ref_fail !== 1'b0 ||
        lock !== 1'b0 || ref_chg !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: mode=%0d sel=%0d hold=%0d fail=%0d lock=%0d chg=%0d exp all 0",
               mode, sel_ref, holdover, ref_fail, lock, ref_chg);
    end
    rst_n = 1'b1;
    // R9 lock qualification over three ticks
    apply(2'b00, 2'b00, 0, 1, 1, 2'd0, 0, 0, 0, "R9 qualify tick1");
    apply(2'b00, 2'b00, 0, 1, 1, 2'd0, 0, 0, 0, "R9 qualify tick2");
    apply(2'b00, 2'b00, 0, 1, 1, 2'd0, 0, 1, 0, "R9 qualify tick3");
    // R2 unselected reference flags ignored
    apply(2'b10, 2'b10, 0, 1, 1, 2'd0, 0, 1, 0, "R2 other ref ignored");
    apply(2'b10, 2'b10, 0, 1, 1, 2'd0, 0, 1, 0, "R2 other ref ignored");
    // R4 short fault, one tick short of the window
    apply(2'b01, 2'b00, 0, 1, 0, 2'd1, 0, 1, 0, "R2 R3 disrupted enters holdover");
    apply(2'b01, 2'b00, 0, 1, 1, 2'd1, 0, 1, 0, "R4 fault tick1");
    apply(2'b01, 2'b00, 0, 1, 1, 2'd1, 0, 1, 0, "R4 fault tick2");
    apply(2'b01, 2'b00, 0, 1, 1, 2'd1, 0, 1, 0, "R4 fault tick3");
    apply(2'b00, 2'b00, 0, 1, 0, 2'd0, 0, 1, 0, "R4 recover same ref");
    // R5 merge select routes through TIE correction
    apply(2'b00, 2'b01, 1, 1, 0, 2'd1, 0, 1, 0, "R2 out of range enters holdover");
    apply(2'b00, 2'b00, 1, 1, 0, 2'd2, 0, 1, 0, "R5 merge to TIE");
    apply(2'b00, 2'b00, 0, 1, 0, 2'd0, 0, 1, 0, "R8 TIE to normal");
    // R8 TIE back to holdover on fault
    apply(2'b01, 2'b00, 1, 1, 0, 2'd1, 0, 1, 0, "R2 enter holdover");
    apply(2'b00, 2'b00, 1, 1, 0, 2'd2, 0, 1, 0, "R5 merge to TIE");
    apply(2'b01, 2'b00, 0, 1, 0, 2'd1, 0, 1, 0, "R8 TIE to holdover");
    apply(2'b00, 2'b00, 0, 1, 0, 2'd0, 0, 1, 0, "R4 recover");
    // R6 failover 0 -> 1, lock kept (R9)
    apply(2'b01, 2'b00, 0, 1, 0, 2'd1, 0, 1, 0, "R6 enter holdover");
    apply(2'b01, 2'b00, 0, 1, 1, 2'd1, 0, 1, 0, "R6 tick1");
    apply(2'b01, 2'b00, 0, 1, 1, 2'd1, 0, 1, 0, "R6 tick2");
    apply(2'b01, 2'b00, 0, 1, 1, 2'd1, 0, 1, 0, "R6 tick3");
    apply(2'b01, 2'b00, 0, 1, 1, 2'd2, 1, 1, 1, "R6 R9 switch to ref1");
    apply(2'b01, 2'b00, 0, 1, 0, 2'd0, 1, 1, 0, "R6 R8 chg one cycle, normal");
    // R6 failover 1 -> 0, then R10 lock drop
    apply(2'b10, 2'b00, 0, 1, 0, 2'd1, 1, 1, 0, "R6 enter holdover on ref1");
    apply(2'b10, 2'b00, 0, 1, 1, 2'd1, 1, 1, 0, "R6 tick1");
    apply(2'b10, 2'b00, 0, 1, 1, 2'd1, 1, 1, 0, "R6 tick2");
    apply(2'b10, 2'b00, 0, 1, 1, 2'd1, 1, 1, 0, "R6 tick3");
    apply(2'b10, 2'b00, 0, 1, 1, 2'd2, 0, 1, 1, "R6 switch to ref0");
    apply(2'b10, 2'b00, 0, 0, 0, 2'd0, 0, 0, 0, "R10 window lost drops lock");
    apply(2'b00, 2'b00, 0, 1, 1, 2'd0, 0, 0, 0, "R10 requalify tick1");
    apply(2'b00, 2'b00, 0, 1, 1, 2'd0, 0, 0, 0, "R10 requalify tick2");
    apply(2'b00, 2'b00, 0, 1, 1, 2'd0, 0, 1, 0, "R10 requalify tick3");
    // R7 both out of range holds without switching
    apply(2'b00, 2'b11, 0, 1, 0, 2'd1, 0, 1, 0, "R7 enter holdover");
    for (int i = 0; i < 6; i++)
      apply(2'b00, 2'b11, 0, 1, 1, 2'd1, 0, 1, 0, "R7 both out of range stay");
    apply(2'b00, 2'b00, 0, 1, 0, 2'd0, 0, 1, 0, "R7 R4 recover ref0");
    repeat (3) @(posedge clk);
    #5;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule